// File: doc/BRIEF.md
# Cache Tag Array Access Controller

This block holds the tag state of an operand cache (512 lines) and an instruction cache (256 lines), both with 32-byte lines, together with their line data. Software reaches the tags and the data through a single register-access port. The port has an array selector, a byte address, write data and a write enable. Reads return one cycle after acceptance.

When software overwrites an operand tag whose line is both valid and dirty, the block first pushes the old line out as a 32-byte burst on a write-back master port. It commits the new tag only after memory acknowledges the burst. A control strobe carries two invalidate bits. They clear the flags of every line of one cache or of both, sweeping one line per clock.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every valid and dirty flag reads as 0, `acc_ready` is 1, and `busy`, `wb_req` and `acc_rvalid` are 0.
- R2: `acc_sel` picks the target array: 0 operand tags, 1 operand data, 2 instruction tags, 3 instruction data. A tag read returns the tag in bits 28:10, the dirty flag in bit 1 (always 0 for instruction tags), the valid flag in bit 0, and zeros elsewhere.
- R3: The operand tag line is `acc_addr[13:5]`. The instruction tag line is `acc_addr[12:5]`, and bit 13 has no effect on it.
- R4: The data arrays are addressed per 32-bit word: operand data by `acc_addr[13:2]`, instruction data by `acc_addr[12:2]`. Read data appears on `acc_rdata` with `acc_rvalid` high in the cycle after the access is accepted. An access is accepted on a clock edge where `acc_req` and `acc_ready` are both high.
- R5: A tag write with `acc_addr[3]`=0 stores only bits 28:10, 1 and 0 of the write data for the operand cache. For the instruction cache it stores only bits 28:10 and 0.
- R6: A tag write with `acc_addr[3]`=1 is accepted but changes no tag, valid or dirty state.
- R7: A direct operand tag write to a line that is valid and dirty raises `wb_req` in the next cycle. `wb_addr` is {old tag bits 28:10, line index bits 4:0, 5'b0}. `wb_data` carries the line, with word k in bits 32k+31:32k. Both stay stable while `wb_req` is high, and `acc_ready` stays low. The new tag is committed on the edge where `wb_done` is high, and `wb_req` then falls.
- R8: A direct operand tag write to a line that is not both valid and dirty commits at once and never raises `wb_req`.
- R9: A control write with `ctl_ici` clears the valid flag of all 256 instruction lines. `busy` is high for exactly 256 cycles, and operand flags are left alone.
- R10: A control write with `ctl_oci` clears valid and dirty on all 512 operand lines without any write-back. `busy` is high for exactly 512 cycles; with both bits set, both caches are cleared within the same 512 cycles.
- R11: While `busy` or `wb_req` is high, `acc_ready` is low and control writes are ignored. In an idle cycle `ctl_we` takes precedence, so `acc_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | Access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 2 | Target array selector |
| acc_addr | input | 14 | Byte address within the array |
| acc_wdata | input | 32 | Write data |
| acc_ready | output | 1 | Access accepted on this edge when requested |
| acc_rvalid | output | 1 | Read data valid |
| acc_rdata | output | 32 | Read data |
| ctl_we | input | 1 | Control write strobe |
| ctl_ici | input | 1 | Invalidate instruction cache |
| ctl_oci | input | 1 | Invalidate operand cache |
| busy | output | 1 | Invalidate sweep in progress |
| wb_req | output | 1 | Write-back burst request |
| wb_addr | output | 29 | Write-back line byte address |
| wb_data | output | 256 | Write-back line contents |
| wb_done | input | 1 | Write-back acknowledge |

## Verification
The checker assumes that `wb_done` is pulsed only while `wb_req` is high. It also assumes that a control write happens only while the block is idle, because the expected sweep length is latched on the starting strobe. The stimulus keeps `acc_req` high until the access is accepted, and it raises `wb_done` only after seeing `wb_req`. Most control writes start from idle, and the single one aimed at a running sweep is meant to be ignored. Random line indices come from a small pool so that rewrites of dirty lines happen often.

// File: rtl/cct_pkg.sv
`timescale 1ns/1ps
package cct_pkg;
  localparam int TAG_HI    = 28;
  localparam int TAG_LO    = 10;
  localparam int TAG_W     = TAG_HI - TAG_LO + 1;
  localparam int LINE_BITS = 256;
  localparam int WB_ADDR_W = 29;

  typedef enum logic [1:0] {
    SEL_OTAG  = 2'd0,
    SEL_ODATA = 2'd1,
    SEL_ITAG  = 2'd2,
    SEL_IDATA = 2'd3
  } cct_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WB    = 2'd1,
    ST_SWEEP = 2'd2
  } cct_state_e;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             dirty;
    logic             valid;
  } cct_entry_t;
endpackage

// File: rtl/cct_tag_bank.sv
`timescale 1ns/1ps
module cct_tag_bank
  import cct_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter bit HAS_DIRTY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output cct_entry_t       rd_entry,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  cct_entry_t       wr_entry,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q;

  // tag bits carry no reset: flags alone decide meaning
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_entry.tag;
  end

  always_comb begin
    valid_d = valid_q;
    if (clr_en) valid_d[clr_idx] = 1'b0;
    if (wr_en)  valid_d[wr_idx]  = wr_entry.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  generate
    if (HAS_DIRTY) begin : g_dirty
      logic [LINES-1:0] dirty_d;
      always_comb begin
        dirty_d = dirty_q;
        if (clr_en) dirty_d[clr_idx] = 1'b0;
        if (wr_en)  dirty_d[wr_idx]  = wr_entry.dirty;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dirty_q <= '0;
        else        dirty_q <= dirty_d;
      end
    end else begin : g_nodirty
      logic unused_dirty;
      assign unused_dirty = wr_entry.dirty;
      assign dirty_q      = '0;
    end
  endgenerate

  assign rd_entry.tag   = tag_mem[rd_idx];
  assign rd_entry.dirty = dirty_q[rd_idx];
  assign rd_entry.valid = valid_q[rd_idx];
endmodule

// File: rtl/cct_line_bank.sv
`timescale 1ns/1ps
module cct_line_bank
  import cct_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IDX_W+2:0]     wr_word,
  input  logic [31:0]          wr_data,
  input  logic [IDX_W+2:0]     rd_word,
  output logic [31:0]          rd_data,
  input  logic [IDX_W-1:0]     line_idx,
  output logic [LINE_BITS-1:0] line_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINE_BITS-1:0] mem [LINES];
  logic [7:0]           wr_bit, rd_bit;

  assign wr_bit = {wr_word[2:0], 5'b0};
  assign rd_bit = {rd_word[2:0], 5'b0};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_word[IDX_W+2:3]][wr_bit +: 32] <= wr_data;
  end

  assign rd_data   = mem[rd_word[IDX_W+2:3]][rd_bit +: 32];
  assign line_data = mem[line_idx];
endmodule

// File: rtl/cct_seq.sv
`timescale 1ns/1ps
module cct_seq
  import cct_pkg::*;
#(
  parameter int OC_IDX_W = 9,
  parameter int IC_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic                 ctl_ici,
  input  logic                 ctl_oci,
  input  logic                 acc_req,
  input  logic                 acc_we,
  input  logic [1:0]           acc_sel,
  input  logic [OC_IDX_W+4:0]  acc_addr,
  input  logic [31:0]          acc_wdata,
  input  cct_entry_t           oc_old,
  input  logic                 wb_done,
  output logic                 acc_ready,
  output logic                 acc_take,
  output logic                 busy,
  output logic                 wb_req,
  output logic [WB_ADDR_W-1:0] wb_addr,
  output logic [OC_IDX_W-1:0]  wb_idx,
  output logic                 oc_wr_en,
  output logic [OC_IDX_W-1:0]  oc_wr_idx,
  output cct_entry_t           oc_wr_entry,
  output logic                 ic_wr_en,
  output logic [IC_IDX_W-1:0]  ic_wr_idx,
  output cct_entry_t           ic_wr_entry,
  output logic                 oc_clr_en,
  output logic                 ic_clr_en,
  output logic [OC_IDX_W-1:0]  clr_idx
);
  localparam int ADDR_W = OC_IDX_W + 5;
  localparam logic [OC_IDX_W-1:0] OC_LAST = '1;
  localparam logic [OC_IDX_W-1:0] IC_LAST = OC_IDX_W'((1 << IC_IDX_W) - 1);
  localparam logic [OC_IDX_W-1:0] ONE     = OC_IDX_W'(1);

  cct_state_e                 state_q, state_d;
  logic [OC_IDX_W-1:0]        cnt_q, cnt_d;
  logic                       sw_i_q, sw_i_d, sw_o_q, sw_o_d;
  logic [OC_IDX_W-1:0]        pidx_q, pidx_d;
  cct_entry_t                 pend_q, pend_d;
  logic [WB_ADDR_W-1:0]       wba_q, wba_d;

  cct_sel_e                   sel;
  logic                       idle, ctl_go, tag_wr, oc_tw, ic_tw, need_wb, sweep_end;
  logic [OC_IDX_W-1:0]        a_idx_oc, sweep_last;
  logic [IC_IDX_W-1:0]        a_idx_ic;
  cct_entry_t                 oc_new, ic_new;
  logic                       unused_bits;

  assign sel       = cct_sel_e'(acc_sel);
  assign idle      = (state_q == ST_IDLE);
  assign acc_ready = idle && !ctl_we;
  assign acc_take  = acc_req && acc_ready;
  assign ctl_go    = idle && ctl_we && (ctl_ici || ctl_oci);
  assign tag_wr    = acc_take && acc_we && !acc_addr[3];
  assign oc_tw     = tag_wr && (sel == SEL_OTAG);
  assign ic_tw     = tag_wr && (sel == SEL_ITAG);
  assign a_idx_oc  = acc_addr[ADDR_W-1:5];
  assign a_idx_ic  = acc_addr[IC_IDX_W+4:5];
  assign need_wb   = oc_tw && oc_old.valid && oc_old.dirty;

  assign oc_new.tag   = acc_wdata[TAG_HI:TAG_LO];
  assign oc_new.dirty = acc_wdata[1];
  assign oc_new.valid = acc_wdata[0];
  assign ic_new.tag   = acc_wdata[TAG_HI:TAG_LO];
  assign ic_new.dirty = 1'b0;
  assign ic_new.valid = acc_wdata[0];

  assign unused_bits = ^{acc_wdata[31:29], acc_wdata[9:2], acc_addr[4], acc_addr[2:0]};

  assign sweep_last = sw_o_q ? OC_LAST : IC_LAST;
  assign sweep_end  = (cnt_q == sweep_last);

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sw_i_d  = sw_i_q;
    sw_o_d  = sw_o_q;
    pidx_d  = pidx_q;
    pend_d  = pend_q;
    wba_d   = wba_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ctl_go) begin
          state_d = ST_SWEEP;
          cnt_d   = '0;
          sw_i_d  = ctl_ici;
          sw_o_d  = ctl_oci;
        end else if (need_wb) begin
          state_d = ST_WB;
          pidx_d  = a_idx_oc;
          pend_d  = oc_new;
          wba_d   = {oc_old.tag, a_idx_oc[4:0], 5'b0};
        end
      end
      ST_WB: begin
        if (wb_done) state_d = ST_IDLE;
      end
      ST_SWEEP: begin
        if (sweep_end) state_d = ST_IDLE;
        else           cnt_d   = cnt_q + ONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sw_i_q  <= 1'b0;
      sw_o_q  <= 1'b0;
      pidx_q  <= '0;
      pend_q  <= '0;
      wba_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sw_i_q  <= sw_i_d;
      sw_o_q  <= sw_o_d;
      pidx_q  <= pidx_d;
      pend_q  <= pend_d;
      wba_q   <= wba_d;
    end
  end

  assign oc_wr_en    = (oc_tw && !need_wb) || ((state_q == ST_WB) && wb_done);
  assign oc_wr_idx   = (state_q == ST_WB) ? pidx_q : a_idx_oc;
  assign oc_wr_entry = (state_q == ST_WB) ? pend_q : oc_new;
  assign ic_wr_en    = ic_tw;
  assign ic_wr_idx   = a_idx_ic;
  assign ic_wr_entry = ic_new;

  assign busy      = (state_q == ST_SWEEP);
  assign oc_clr_en = busy && sw_o_q;
  assign ic_clr_en = busy && sw_i_q && (cnt_q <= IC_LAST);
  assign clr_idx   = cnt_q;
  assign wb_req    = (state_q == ST_WB);
  assign wb_addr   = wba_q;
  assign wb_idx    = pidx_q;
endmodule

// File: rtl/cache_tag_ctrl.sv
`timescale 1ns/1ps
module cache_tag_ctrl
  import cct_pkg::*;
#(
  parameter int OC_IDX_W = 9,
  parameter int IC_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_req,
  input  logic                 acc_we,
  input  logic [1:0]           acc_sel,
  input  logic [OC_IDX_W+4:0]  acc_addr,
  input  logic [31:0]          acc_wdata,
  output logic                 acc_ready,
  output logic                 acc_rvalid,
  output logic [31:0]          acc_rdata,
  input  logic                 ctl_we,
  input  logic                 ctl_ici,
  input  logic                 ctl_oci,
  output logic                 busy,
  output logic                 wb_req,
  output logic [WB_ADDR_W-1:0] wb_addr,
  output logic [LINE_BITS-1:0] wb_data,
  input  logic                 wb_done
);
  localparam int ADDR_W = OC_IDX_W + 5;

  logic                 acc_take;
  cct_entry_t           oc_rd, ic_rd, oc_wr_entry, ic_wr_entry;
  logic                 oc_wr_en, ic_wr_en, oc_clr_en, ic_clr_en;
  logic [OC_IDX_W-1:0]  oc_wr_idx, clr_idx, wb_idx;
  logic [IC_IDX_W-1:0]  ic_wr_idx;
  logic [31:0]          od_rd, id_rd, rdata_d, rdata_q;
  logic                 rvalid_q, rd_take, od_we, id_we;
  logic [LINE_BITS-1:0] unused_ic_line;
  logic                 unused_lsb;

  function automatic logic [31:0] entry_word(input cct_entry_t e);
    return {3'b0, e.tag, 8'b0, e.dirty, e.valid};
  endfunction

  cct_seq #(.OC_IDX_W(OC_IDX_W), .IC_IDX_W(IC_IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_ici(ctl_ici), .ctl_oci(ctl_oci),
    .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .oc_old(oc_rd), .wb_done(wb_done),
    .acc_ready(acc_ready), .acc_take(acc_take), .busy(busy),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_idx(wb_idx),
    .oc_wr_en(oc_wr_en), .oc_wr_idx(oc_wr_idx), .oc_wr_entry(oc_wr_entry),
    .ic_wr_en(ic_wr_en), .ic_wr_idx(ic_wr_idx), .ic_wr_entry(ic_wr_entry),
    .oc_clr_en(oc_clr_en), .ic_clr_en(ic_clr_en), .clr_idx(clr_idx)
  );

  cct_tag_bank #(.IDX_W(OC_IDX_W), .HAS_DIRTY(1'b1)) u_otag (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(acc_addr[ADDR_W-1:5]), .rd_entry(oc_rd),
    .wr_en(oc_wr_en), .wr_idx(oc_wr_idx), .wr_entry(oc_wr_entry),
    .clr_en(oc_clr_en), .clr_idx(clr_idx)
  );

  cct_tag_bank #(.IDX_W(IC_IDX_W), .HAS_DIRTY(1'b0)) u_itag (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(acc_addr[IC_IDX_W+4:5]), .rd_entry(ic_rd),
    .wr_en(ic_wr_en), .wr_idx(ic_wr_idx), .wr_entry(ic_wr_entry),
    .clr_en(ic_clr_en), .clr_idx(clr_idx[IC_IDX_W-1:0])
  );

  assign od_we = acc_take && acc_we && (acc_sel == SEL_ODATA);
  assign id_we = acc_take && acc_we && (acc_sel == SEL_IDATA);

  cct_line_bank #(.IDX_W(OC_IDX_W)) u_odata (
    .clk(clk), .wr_en(od_we),
    .wr_word(acc_addr[ADDR_W-1:2]), .wr_data(acc_wdata),
    .rd_word(acc_addr[ADDR_W-1:2]), .rd_data(od_rd),
    .line_idx(wb_idx), .line_data(wb_data)
  );

  cct_line_bank #(.IDX_W(IC_IDX_W)) u_idata (
    .clk(clk), .wr_en(id_we),
    .wr_word(acc_addr[IC_IDX_W+4:2]), .wr_data(acc_wdata),
    .rd_word(acc_addr[IC_IDX_W+4:2]), .rd_data(id_rd),
    .line_idx('0), .line_data(unused_ic_line)
  );

  assign unused_lsb = ^acc_addr[1:0];
  assign rd_take    = acc_take && !acc_we;

  always_comb begin
    unique case (acc_sel)
      SEL_OTAG:  rdata_d = entry_word(oc_rd);
      SEL_ODATA: rdata_d = od_rd;
      SEL_ITAG:  rdata_d = entry_word(ic_rd);
      default:   rdata_d = id_rd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_take;
      if (rd_take) rdata_q <= rdata_d;
    end
  end

  assign acc_rdata  = rdata_q;
  assign acc_rvalid = rvalid_q;
endmodule

// File: rtl/cct_chk.sv
`timescale 1ns/1ps
module cct_chk
  import cct_pkg::*;
#(
  parameter int OC_IDX_W = 9,
  parameter int IC_IDX_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_req,
  input logic                 acc_we,
  input logic                 acc_ready,
  input logic                 acc_rvalid,
  input logic                 ctl_we,
  input logic                 ctl_ici,
  input logic                 ctl_oci,
  input logic                 busy,
  input logic                 wb_req,
  input logic [WB_ADDR_W-1:0] wb_addr,
  input logic [LINE_BITS-1:0] wb_data,
  input logic                 wb_done
);
  localparam logic [31:0] OC_LINES = 32'(1 << OC_IDX_W);
  localparam logic [31:0] IC_LINES = 32'(1 << IC_IDX_W);

  logic [31:0] sweep_cnt, sweep_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_cnt <= '0;
      sweep_exp <= '0;
    end else if (ctl_we && !busy && !wb_req && (ctl_ici || ctl_oci)) begin
      sweep_cnt <= '0;
      sweep_exp <= ctl_oci ? OC_LINES : IC_LINES;
    end else if (busy) begin
      sweep_cnt <= sweep_cnt + 32'd1;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_done |=> wb_req);                                  // R7
  AST_WB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_done |=> $stable(wb_addr) && $stable(wb_data));    // R7
  AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !acc_ready);                                          // R7
  AST_SWEEP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !acc_ready);                                            // R11
  AST_CTL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |-> !acc_ready);                                          // R11
  AST_NO_WB_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && wb_req));                                              // R10
  AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_ready && !acc_we |=> acc_rvalid);                 // R4
  AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $past(acc_req && acc_ready && !acc_we));          // R4
  AST_SWEEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sweep_cnt == sweep_exp);                         // R9
endmodule

bind cache_tag_ctrl cct_chk #(.OC_IDX_W(OC_IDX_W), .IC_IDX_W(IC_IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
  .acc_ready(acc_ready), .acc_rvalid(acc_rvalid),
  .ctl_we(ctl_we), .ctl_ici(ctl_ici), .ctl_oci(ctl_oci),
  .busy(busy), .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
  .wb_done(wb_done)
);

// File: tb/sim_cache_tag_ctrl.sv
`timescale 1ns/1ps
module sim_cache_tag_ctrl;
  logic         clk, rst_n;
  logic         acc_req, acc_we, acc_ready, acc_rvalid;
  logic [1:0]   acc_sel;
  logic [13:0]  acc_addr;
  logic [31:0]  acc_wdata, acc_rdata;
  logic         ctl_we, ctl_ici, ctl_oci, busy;
  logic         wb_req, wb_done;
  logic [28:0]  wb_addr;
  logic [255:0] wb_data;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] m_ot [int];
  logic [31:0] m_it [int];
  logic [31:0] m_od [int];
  logic [31:0] m_id [int];

  cache_tag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_sel(acc_sel), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_ready(acc_ready), .acc_rvalid(acc_rvalid), .acc_rdata(acc_rdata),
    .ctl_we(ctl_we), .ctl_ici(ctl_ici), .ctl_oci(ctl_oci), .busy(busy),
    .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data), .wb_done(wb_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] omask(input logic [31:0] v);
    return v & 32'h1FFF_FC03;
  endfunction
  function automatic logic [31:0] imask(input logic [31:0] v);
    return v & 32'h1FFF_FC01;
  endfunction

  task automatic access(input bit we, input logic [1:0] sel, input logic [13:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_sel = sel; acc_addr = addr; acc_wdata = wd;
    #1;
    while (acc_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    acc_req = 1'b0; acc_we = 1'b0;
    if (!we) check("R4 rvalid", {31'b0, acc_rvalid}, 32'd1);
    rd = acc_rdata;
  endtask

  task automatic otag_write(input logic [8:0] idx, input bit assoc, input logic [31:0] val);
    logic [31:0] rd, old;
    bit wb_exp;
    wb_exp = 0;
    old = '0;
    if (m_ot.exists(int'(idx))) old = m_ot[int'(idx)];
    wb_exp = !assoc && (old[1:0] == 2'b11);
    access(1'b1, 2'd0, {idx, 1'b0, assoc, 3'b0}, val, rd);
    if (wb_exp) begin
      check("R7 wb_req", {31'b0, wb_req}, 32'd1);
      check("R7 wb_addr", {3'b0, wb_addr}, {3'b0, old[28:10], idx[4:0], 5'b0});
      for (int k = 0; k < 8; k++)
        if (m_od.exists(int'(idx) * 8 + k))
          check("R7 wb_data", wb_data[k*32 +: 32], m_od[int'(idx) * 8 + k]);
      check("R7 stall", {31'b0, acc_ready}, 32'd0);
      repeat ($urandom_range(1, 4)) begin
        @(posedge clk); #1;
        check("R7 hold", {31'b0, wb_req}, 32'd1);
      end
      @(negedge clk); wb_done = 1'b1;
      @(posedge clk); #1; wb_done = 1'b0;
      check("R7 release", {31'b0, wb_req}, 32'd0);
    end else begin
      check("R8 no write-back", {31'b0, wb_req}, 32'd0);
    end
    if (!assoc) m_ot[int'(idx)] = omask(val);
  endtask

  task automatic otag_read(input logic [8:0] idx, input string req);
    logic [31:0] rd;
    access(1'b0, 2'd0, {idx, 5'b0}, 32'd0, rd);
    if (m_ot.exists(int'(idx))) check(req, rd, m_ot[int'(idx)]);
    else check("R1 flags clear", {30'b0, rd[1:0]}, 32'd0);
  endtask

  task automatic itag_write(input logic [7:0] idx, input bit hi, input bit assoc, input logic [31:0] val);
    logic [31:0] rd;
    access(1'b1, 2'd2, {hi, idx, 1'b0, assoc, 3'b0}, val, rd);
    if (!assoc) m_it[int'(idx)] = imask(val);
  endtask

  task automatic itag_read(input logic [7:0] idx, input bit hi, input string req);
    logic [31:0] rd;
    access(1'b0, 2'd2, {hi, idx, 5'b0}, 32'd0, rd);
    if (m_it.exists(int'(idx))) check(req, rd, m_it[int'(idx)]);
    else check("R1 flags clear", {30'b0, rd[1:0]}, 32'd0);
  endtask

  task automatic odata_write(input logic [11:0] w, input logic [31:0] val);
    logic [31:0] rd;
    access(1'b1, 2'd1, {w, 2'b0}, val, rd);
    m_od[int'(w)] = val;
  endtask

  task automatic odata_read(input logic [11:0] w);
    logic [31:0] rd;
    access(1'b0, 2'd1, {w, 2'b0}, 32'd0, rd);
    if (m_od.exists(int'(w))) check("R4 operand data", rd, m_od[int'(w)]);
  endtask

  task automatic idata_write(input logic [10:0] w, input bit hi, input logic [31:0] val);
    logic [31:0] rd;
    access(1'b1, 2'd3, {hi, w, 2'b0}, val, rd);
    m_id[int'(w)] = val;
  endtask

  task automatic idata_read(input logic [10:0] w, input bit hi);
    logic [31:0] rd;
    access(1'b0, 2'd3, {hi, w, 2'b0}, 32'd0, rd);
    if (m_id.exists(int'(w))) check("R4 instruction data", rd, m_id[int'(w)]);
  endtask

  task automatic sweep(input bit ici, input bit oci, input bit inject);
    int n;
    @(negedge clk);
    ctl_we = 1'b1; ctl_ici = ici; ctl_oci = oci;
    acc_req = 1'b1; acc_we = 1'b0; acc_sel = 2'd0; acc_addr = '0;
    #1;
    check("R11 control precedence", {31'b0, acc_ready}, 32'd0);
    @(posedge clk); #1;
    ctl_we = 1'b0; acc_req = 1'b0;
    check("R11 access dropped", {31'b0, acc_rvalid}, 32'd0);
    n = 0;
    while (busy === 1'b1 && n < 2000) begin
      n++;
      if (n == 10) begin
        @(negedge clk);
        ctl_we = inject; ctl_ici = 1'b1; ctl_oci = 1'b1;
        #1;
        check("R11 stall in sweep", {31'b0, acc_ready}, 32'd0);
      end
      @(posedge clk); #1;
      ctl_we = 1'b0;
    end
    if (oci) check("R10 sweep length", n, 512);
    else     check("R9 sweep length", n, 256);
    check("R10 no write-back in sweep", {31'b0, wb_req}, 32'd0);
    if (ici) foreach (m_it[k]) m_it[k][0] = 1'b0;
    if (oci) foreach (m_ot[k]) m_ot[k][1:0] = 2'b00;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd1234));
    rst_n = 1'b0; acc_req = 0; acc_we = 0; acc_sel = 0; acc_addr = 0; acc_wdata = 0;
    ctl_we = 0; ctl_ici = 0; ctl_oci = 0; wb_done = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 ready", {31'b0, acc_ready}, 32'd1);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 wb_req", {31'b0, wb_req}, 32'd0);
    check("R1 rvalid", {31'b0, acc_rvalid}, 32'd0);
    otag_read(9'd3, "R1");
    itag_read(8'd9, 1'b0, "R1");

    // R2 R5: masking and field layout
    otag_write(9'd7, 1'b0, 32'hFFFF_FFFC);
    otag_read(9'd7, "R5 operand mask");
    itag_write(8'd7, 1'b0, 1'b0, 32'hFFFF_FFFF);
    itag_read(8'd7, 1'b0, "R5 instruction mask");
    // R3: bit 13 ignored for instruction tags
    itag_read(8'd7, 1'b1, "R3 instruction alias");
    otag_write(9'd263, 1'b0, 32'h0012_3401);
    otag_read(9'd263, "R3 operand bit13");
    otag_read(9'd7, "R3 operand distinct");

    // R7: dirty line flush
    for (int k = 0; k < 8; k++) odata_write({9'd3, 3'(k)}, 32'hA500_0000 + k);
    otag_write(9'd3, 1'b0, 32'h0ABC_D403);
    otag_write(9'd3, 1'b0, 32'h0111_1401);
    otag_read(9'd3, "R7 new tag committed");
    // R8: valid only, then dirty only
    otag_write(9'd3, 1'b0, 32'h0222_2402);
    otag_write(9'd3, 1'b0, 32'h0333_3403);
    otag_read(9'd3, "R8 commit");
    // R6: associative writes leave state alone
    otag_write(9'd3, 1'b1, 32'h0000_0000);
    otag_read(9'd3, "R6 operand assoc ignored");
    itag_write(8'd7, 1'b0, 1'b1, 32'h0000_0000);
    itag_read(8'd7, 1'b0, "R6 instruction assoc ignored");
    idata_write(11'd100, 1'b1, 32'hCAFE_0001);
    idata_read(11'd100, 1'b0);

    // R9 R11: instruction sweep with an ignored control write inside
    sweep(1'b1, 1'b0, 1'b1);
    itag_read(8'd7, 1'b0, "R9 instruction cleared");
    otag_read(9'd3, "R11 operand untouched");
    // R10: operand sweep, no flush of dirty line 3
    sweep(1'b0, 1'b1, 1'b0);
    otag_read(9'd3, "R10 operand cleared");
    otag_write(9'd3, 1'b0, 32'h0444_4403);
    sweep(1'b1, 1'b1, 1'b0);
    otag_read(9'd3, "R10 both cleared");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [8:0]  oi;
      logic [7:0]  ii;
      logic [31:0] v;
      oi = 9'((($urandom % 4) << 7) | ($urandom % 8));
      ii = 8'((($urandom % 4) << 6) | ($urandom % 8));
      v  = $urandom;
      case ($urandom % 8)
        0, 1: otag_write(oi, ($urandom % 6) == 0, v);
        2:    otag_read(oi, "R2 operand tag");
        3:    itag_write(ii, 1'($urandom), ($urandom % 6) == 0, v);
        4:    itag_read(ii, 1'($urandom), "R2 instruction tag");
        5:    odata_write({oi, 3'($urandom)}, v);
        6:    odata_read({oi, 3'($urandom)});
        default: begin
          idata_write({ii, 3'($urandom)}, 1'($urandom), v);
          idata_read({ii, 3'($urandom)}, 1'($urandom));
        end
      endcase
    end
    rd = '0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule